// File: doc/BRIEF.md
# Self-routing banyan switching network

This block moves fixed-length cells from eight input ports to eight output ports through three stages of 2x2 binary switching elements, twelve elements in all. Each cell carries its own destination address. Every element makes its choice of output from one address bit, so no central controller works out paths. Each cycle an input port may offer one cell: a valid bit, a 3-bit destination and a tag. A cell either comes out on the output port its destination names, or it is reported as blocked because another cell held an internal link it needed.

Each stage is registered, so the network takes a new set of cells every cycle and delivers them after a fixed three-cycle latency. The cell's source port index travels with it. When two cells collide inside an element, the one on the element's upper input continues. The other is dropped, and the blocked flag of the input port it entered on is raised. That flag comes in the same cycle the dropped cell would have come out, so the port logic can resend it. Buffering of losers, segmentation and header parsing are handled outside the block.

Top module: `banyan_net`

## Requirements
- R1: A cell offered before clock edge n appears at an output, or is reported blocked, just after edge n+2 (three cycles of latency) and not earlier.
- R2: A delivered cell leaves on the output port whose index equals its 3-bit destination. The destination and tag are unchanged, and `out_src` gives the input port index the cell entered on.
- R3: A lone cell offered on any of the eight inputs reaches any of the eight outputs.
- R4: Wiring and contention work as follows. Lines are numbered 0 to 7. Before each stage, the cell on line j moves to line ((2j) mod 8) + (j div 4), a 3-bit left rotate. Stage k (k = 0, 1, 2) has element e joining line 2e (upper) and line 2e+1 (lower), and it sends a cell to line 2e+b, where b is destination bit 2-k. When both cells pick the same line, the upper one goes on and the lower one is dropped. For a dropped cell, `blocked[i]` is raised, where i is that cell's input port, in the cycle it would otherwise have come out.
- R5: For each set of cells offered in one cycle, the number delivered plus the number of blocked flags raised equals the number offered.
- R6: An output port with no cell reaching it in a cycle shows `out_valid` low. A blocked flag is low unless its input's cell was dropped.
- R7: An active-low asynchronous reset discards every cell in flight. `out_valid` and `blocked` stay low during reset and until cells offered after reset have had three cycles to pass through.
- R8: A new set of cells is accepted every cycle, and sets offered in consecutive cycles do not interact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 8 | Per input port: a cell is offered this cycle |
| in_dest | input | 24 | Per input port 3-bit destination, port i at bits [3i+2:3i] |
| in_tag | input | 64 | Per input port 8-bit payload tag, port i at bits [8i+7:8i] |
| out_valid | output | 8 | Per output port: a cell is delivered this cycle |
| out_dest | output | 24 | Destination field of the delivered cell, port p at bits [3p+2:3p] |
| out_src | output | 24 | Input port index of the delivered cell, port p at bits [3p+2:3p] |
| out_tag | output | 64 | Tag of the delivered cell, port p at bits [8p+7:8p] |
| blocked | output | 8 | Per input port: its cell offered three cycles earlier was dropped |

## Verification
A shuffle link wired to the wrong position, or an element testing the wrong address bit, sends a cell to an output that differs from its destination. That shows on the first cycle a cell is delivered, three cycles after it is offered. A fault in how contention is settled shows in the same cycle as a changed winner, a missing or extra blocked flag, or a delivered-plus-blocked count that no longer matches what was offered. A stage register that holds stale contents brings out cells or flags in a wave that offered none, so it is visible one cycle after an idle cycle has passed through.

// File: rtl/banyan_pkg.sv
package banyan_pkg;

    localparam int PORTS  = 8;
    localparam int ADDR_W = $clog2(PORTS);
    localparam int TAG_W  = 8;
    localparam int HALF   = PORTS / 2;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] dest;
        logic [ADDR_W-1:0] src;
        logic [TAG_W-1:0]  tag;
    } cell_t;

endpackage

// File: rtl/banyan_elem.sv
module banyan_elem
    import banyan_pkg::*;
#(
    parameter int BIT = 0
) (
    input  cell_t             up_i,
    input  cell_t             lo_i,
    output cell_t             out0_o,
    output cell_t             out1_o,
    output logic              drop_o,
    output logic [ADDR_W-1:0] drop_src_o
);

    logic clash;

    always_comb begin
        clash      = up_i.valid && lo_i.valid && (up_i.dest[BIT] == lo_i.dest[BIT]);
        out0_o     = '0;
        out1_o     = '0;
        drop_o     = clash;
        drop_src_o = lo_i.src;
        if (up_i.valid) begin
            if (up_i.dest[BIT]) out1_o = up_i;
            else                out0_o = up_i;
        end
        if (lo_i.valid && !clash) begin
            if (lo_i.dest[BIT]) out1_o = lo_i;
            else                out0_o = lo_i;
        end
    end

endmodule

// File: rtl/banyan_stage.sv
module banyan_stage
    import banyan_pkg::*;
#(
    parameter int STAGE = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  cell_t [PORTS-1:0]       line_i,
    input  logic  [PORTS-1:0]       blk_i,
    output cell_t [PORTS-1:0]       line_o,
    output logic  [PORTS-1:0]       blk_o
);

    localparam int BIT = ADDR_W - 1 - STAGE;

    typedef struct packed {
        cell_t [PORTS-1:0] line;
        logic  [PORTS-1:0] blk;
    } stage_t;

    cell_t [PORTS-1:0]  shuf;
    cell_t [PORTS-1:0]  sw;
    logic  [HALF-1:0]   drop;
    logic  [ADDR_W-1:0] dsrc [HALF];
    stage_t             st_d;
    stage_t             st_q;

    for (genvar j = 0; j < PORTS; j++) begin : g_shuffle
        localparam int DST = ((j * 2) % PORTS) + (j / HALF);
        assign shuf[DST] = line_i[j];
    end

    for (genvar e = 0; e < HALF; e++) begin : g_elem
        banyan_elem #(.BIT(BIT)) u_elem (
            .up_i       (shuf[2*e]),
            .lo_i       (shuf[2*e+1]),
            .out0_o     (sw[2*e]),
            .out1_o     (sw[2*e+1]),
            .drop_o     (drop[e]),
            .drop_src_o (dsrc[e])
        );
    end

    always_comb begin
        st_d.line = sw;
        st_d.blk  = blk_i;
        for (int e = 0; e < HALF; e++) begin
            if (drop[e]) st_d.blk[dsrc[e]] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_o = st_q.line;
    assign blk_o  = st_q.blk;

endmodule

// File: rtl/banyan_net.sv
module banyan_net
    import banyan_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PORTS-1:0]          in_valid,
    input  logic [PORTS*ADDR_W-1:0]   in_dest,
    input  logic [PORTS*TAG_W-1:0]    in_tag,
    output logic [PORTS-1:0]          out_valid,
    output logic [PORTS*ADDR_W-1:0]   out_dest,
    output logic [PORTS*ADDR_W-1:0]   out_src,
    output logic [PORTS*TAG_W-1:0]    out_tag,
    output logic [PORTS-1:0]          blocked
);

    cell_t [PORTS-1:0] lane [ADDR_W+1];
    logic  [PORTS-1:0] blk  [ADDR_W+1];

    always_comb begin
        for (int i = 0; i < PORTS; i++) begin
            lane[0][i].valid = in_valid[i];
            lane[0][i].dest  = in_dest[i*ADDR_W +: ADDR_W];
            lane[0][i].src   = ADDR_W'(i);
            lane[0][i].tag   = in_tag[i*TAG_W +: TAG_W];
        end
        blk[0] = '0;
    end

    for (genvar g = 0; g < ADDR_W; g++) begin : g_stage
        banyan_stage #(.STAGE(g)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (lane[g]),
            .blk_i  (blk[g]),
            .line_o (lane[g+1]),
            .blk_o  (blk[g+1])
        );
    end

    always_comb begin
        for (int p = 0; p < PORTS; p++) begin
            out_valid[p]                  = lane[ADDR_W][p].valid;
            out_dest[p*ADDR_W +: ADDR_W]  = lane[ADDR_W][p].dest;
            out_src[p*ADDR_W +: ADDR_W]   = lane[ADDR_W][p].src;
            out_tag[p*TAG_W +: TAG_W]     = lane[ADDR_W][p].tag;
        end
        blocked = blk[ADDR_W];
    end

endmodule

// File: rtl/banyan_net_chk.sv
module banyan_net_chk
    import banyan_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic [PORTS-1:0]        in_valid,
    input logic [PORTS-1:0]        out_valid,
    input logic [PORTS*ADDR_W-1:0] out_dest,
    input logic [PORTS*ADDR_W-1:0] out_src,
    input logic [PORTS-1:0]        blocked
);

    int unsigned age;
    logic        warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age <= 0;
        else if (age < ADDR_W) age <= age + 1;
    end

    assign warm = (age == ADDR_W);

    AST_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> ($countones(out_valid) + $countones(blocked)) == $countones($past(in_valid, ADDR_W))); // R5

    AST_BLOCK_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (blocked & ~$past(in_valid, ADDR_W)) == '0); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid, ADDR_W) == '0) |-> (out_valid == '0 && blocked == '0)); // R6

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        AST_DEST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[p] |-> out_dest[p*ADDR_W +: ADDR_W] == ADDR_W'(p)); // R2

        AST_SRC_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
            (warm && out_valid[p]) |-> ((($past(in_valid, ADDR_W)) >> out_src[p*ADDR_W +: ADDR_W]) & 1) == 1); // R1
    end

endmodule

bind banyan_net banyan_net_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_dest  (out_dest),
    .out_src   (out_src),
    .blocked   (blocked)
);

// File: tb/banyan_net_bench.sv
module banyan_net_bench;
    import banyan_pkg::*;

    localparam int AW   = ADDR_W;
    localparam int MAXW = 256;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [PORTS-1:0]      in_valid = '0;
    logic [PORTS*AW-1:0]   in_dest = '0;
    logic [PORTS*TAG_W-1:0] in_tag = '0;
    logic [PORTS-1:0]      out_valid;
    logic [PORTS*AW-1:0]   out_dest;
    logic [PORTS*AW-1:0]   out_src;
    logic [PORTS*TAG_W-1:0] out_tag;
    logic [PORTS-1:0]      blocked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [PORTS-1:0] wv [MAXW];
    logic [AW-1:0]    wd [MAXW][PORTS];

    logic [PORTS-1:0] exp_v;
    logic [AW-1:0]    exp_s [PORTS];
    logic [PORTS-1:0] exp_b;

    always #5 clk = ~clk;

    banyan_net u_banyan_net (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_dest   (in_dest),
        .in_tag    (in_tag),
        .out_valid (out_valid),
        .out_dest  (out_dest),
        .out_src   (out_src),
        .out_tag   (out_tag),
        .blocked   (blocked)
    );

    function automatic logic [TAG_W-1:0] tag_of(int w, int s);
        return TAG_W'(w * PORTS + s);
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Expected routing computed from the wiring rule of R4
    task automatic model(int w);
        logic [PORTS-1:0] pv, nv, ov;
        int ps [PORTS];
        int ns [PORTS];
        int os [PORTS];
        pv = wv[w];
        exp_b = '0;
        for (int i = 0; i < PORTS; i++) ps[i] = i;
        for (int k = 0; k < AW; k++) begin
            for (int j = 0; j < PORTS; j++) begin
                int t;
                t = ((2 * j) % PORTS) + (j / (PORTS / 2));
                nv[t] = pv[j];
                ns[t] = ps[j];
            end
            ov = '0;
            for (int i = 0; i < PORTS; i++) os[i] = 0;
            for (int e = 0; e < PORTS / 2; e++) begin
                int u, l, bu, bl;
                u  = 2 * e;
                l  = 2 * e + 1;
                bu = int'(wd[w][ns[u]][AW-1-k]);
                bl = int'(wd[w][ns[l]][AW-1-k]);
                if (nv[u]) begin
                    ov[u + bu] = 1'b1;
                    os[u + bu] = ns[u];
                end
                if (nv[l]) begin
                    if (nv[u] && bu == bl) exp_b[ns[l]] = 1'b1;
                    else begin
                        ov[u + bl] = 1'b1;
                        os[u + bl] = ns[l];
                    end
                end
            end
            pv = ov;
            for (int i = 0; i < PORTS; i++) ps[i] = os[i];
        end
        exp_v = pv;
        for (int i = 0; i < PORTS; i++) exp_s[i] = AW'(ps[i]);
    endtask

    task automatic check_wave(int w);
        model(w);
        for (int p = 0; p < PORTS; p++) begin
            if (exp_v[p]) begin
                int s;
                s = int'(exp_s[p]);
                chk(out_valid[p] && out_src[p*AW +: AW] == exp_s[p]
                    && out_dest[p*AW +: AW] == AW'(p)
                    && out_tag[p*TAG_W +: TAG_W] == tag_of(w, s),
                    "R2/R4", $sformatf("wave %0d port %0d {v,src,dest,tag}", w, p),
                    {out_valid[p], out_src[p*AW +: AW], out_dest[p*AW +: AW], out_tag[p*TAG_W +: TAG_W]},
                    {1'b1, exp_s[p], AW'(p), tag_of(w, s)});
            end else begin
                chk(!out_valid[p], "R6", $sformatf("wave %0d port %0d idle", w, p),
                    out_valid[p], 0);
            end
        end
        chk(blocked == exp_b, "R4", $sformatf("wave %0d blocked", w), blocked, exp_b);
        chk($countones(out_valid) + $countones(blocked) == $countones(wv[w]), "R5",
            $sformatf("wave %0d delivered+blocked", w),
            $countones(out_valid) + $countones(blocked), $countones(wv[w]));
    endtask

    task automatic drive(int w, bit on);
        for (int i = 0; i < PORTS; i++) begin
            in_valid[i]               = on ? wv[w][i] : 1'b0;
            in_dest[i*AW +: AW]       = on ? wd[w][i] : '0;
            in_tag[i*TAG_W +: TAG_W]  = on ? tag_of(w, i) : '0;
        end
    endtask

    // Waves first..first+cnt-1 back to back; pipeline assumed empty on entry
    task automatic run_seq(int first, int cnt);
        for (int k = 0; k < cnt + AW; k++) begin
            @(negedge clk);
            if (k >= AW) check_wave(first + k - AW);
            else chk(out_valid == '0 && blocked == '0, "R1",
                     $sformatf("nothing early, wave %0d step %0d", first, k),
                     {out_valid, blocked}, 0);
            drive(first + k, k < cnt);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int w;
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        chk(out_valid == '0 && blocked == '0, "R7", "outputs in reset", {out_valid, blocked}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == '0 && blocked == '0, "R7", "outputs after reset", {out_valid, blocked}, 0);

        // R3: every lone source to every destination
        w = 0;
        for (int s = 0; s < PORTS; s++) begin
            for (int d = 0; d < PORTS; d++) begin
                wv[w] = '0;
                wv[w][s] = 1'b1;
                for (int i = 0; i < PORTS; i++) wd[w][i] = AW'(d);
                run_seq(w, 1);
                w++;
            end
        end

        // Full patterns: identity, reversal, bit reversal, rotation, all to one, sparse contention
        for (int pat = 0; pat < 6; pat++) begin
            wv[w] = '1;
            for (int i = 0; i < PORTS; i++) begin
                case (pat)
                    0: wd[w][i] = AW'(i);
                    1: wd[w][i] = AW'(PORTS - 1 - i);
                    2: wd[w][i] = {<<{AW'(i)}};
                    3: wd[w][i] = AW'(i + 3);
                    4: wd[w][i] = AW'(5);
                    default: wd[w][i] = AW'(i / 2);
                endcase
            end
            if (pat == 5) begin
                wv[w] = 8'b0001_1010;
                wd[w][1] = 3'd0;
                wd[w][3] = 3'd1;
                wd[w][4] = 3'd5;
            end
            run_seq(w, 1);
            w++;
        end

        // R8: pseudo-random waves back to back
        lfsr = 16'hACE1;
        for (int n = 0; n < 150; n++) begin
            for (int i = 0; i < PORTS; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                wd[w + n][i] = lfsr[AW-1:0];
                wv[w + n][i] = lfsr[7] | lfsr[9];
            end
        end
        run_seq(w, 150);
        w += 150;

        // R7: reset while cells are in flight
        wv[w] = '1;
        for (int i = 0; i < PORTS; i++) wd[w][i] = AW'(i);
        @(negedge clk);
        drive(w, 1'b1);
        @(negedge clk);
        drive(w, 1'b0);
        rst_n = 1'b0;
        #1;
        chk(out_valid == '0 && blocked == '0, "R7", "cleared by reset", {out_valid, blocked}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < AW + 1; k++) begin
            @(negedge clk);
            chk(out_valid == '0 && blocked == '0, "R7",
                $sformatf("no flushed cell, step %0d", k), {out_valid, blocked}, 0);
        end
        run_seq(w, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule